// File: doc/BRIEF.md
# Permuted-Output Congruential Random Word Generator

The block keeps a 64-bit linear congruential state and hands out one 32-bit pseudorandom word for each request. Each word is a scrambled view of the state, not the raw state. The state is first mixed with a right-shifted copy of itself. A 32-bit window of that mix is then rotated right by an amount read from the top state bits. The word is always derived from the state as it stood before the advance that the same request causes.

Software-free use is intended. Reset puts a fixed starting state in place. A seed load, with a one-cycle setup step, moves the generator to a chosen point. A stream input changes the additive constant, so several instances can run independent sequences. Each `next_i` pulse returns one word, flagged by a single-cycle `valid_o`.

Top module: `pcg_rng`

## Requirements
- R1: Synchronous reset sets the state to 0x4d595df4d0f33173 and holds `valid_o` low; the first word after reset is the permutation of that state.
- R2: Each advance computes state = state × 6364136223846793005 + inc, modulo 2^64.
- R3: The increment inc equals 1442695040888963407 XOR `stream_i`, with bit 0 forced to 1; with `stream_i` = 0 the default stream results.
- R4: The word is formed by XORing the state with the state shifted right by 18, taking bits 58..27 of that value, and rotating them right by the amount in state bits 63..59.
- R5: The word returned for a request is computed from the state before that request's advance.
- R6: A load sets the state to `seed_i` + inc, and the following cycle advances the state once without producing a word; `valid_o` is low in both cycles.
- R7: When `load_i` and `next_i` are high in the same cycle, the load takes effect and no word is produced.
- R8: A `next_i` pulse in the setup cycle that follows a load is ignored: no word is produced and the state advances only once.
- R9: Each accepted `next_i` cycle yields exactly one word with `valid_o` high for one cycle; while `next_i` and `load_i` are low the state does not change.
- R10: When state bits 63..59 are zero, the word equals bits 58..27 of the mixed value unrotated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Seed load strobe |
| seed_i | input | 64 | Seed value sampled with `load_i` |
| stream_i | input | 64 | Stream selector XORed into the default increment |
| next_i | input | 1 | Request for one output word |
| rand_o | output | 32 | Pseudorandom word |
| valid_o | output | 1 | High for one cycle when `rand_o` holds a new word |

## Verification
The bench places the state directly on chosen values by inverting the update: it picks a target state whose top five bits are zero or one and derives the seed that lands there, so a design that misreads the rotate field or rotates the wrong way returns a shifted word. Load together with a request, and a request in the setup cycle, are driven; a design with the wrong priority or that honours the setup-cycle request emits a stray valid pulse or is one step ahead afterwards. Idle gaps between requests of varying length expose a state that drifts while no word is asked for, and words taken from the post-update state show up as the whole sequence shifted by one.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

   localparam logic [63:0] PCG_MULT_64 = 64'h5851_F42D_4C95_7F2D;
   localparam logic [63:0] PCG_INC_64  = 64'h1405_7B7E_F767_814F;
   localparam logic [63:0] PCG_INIT_64 = 64'h4D59_5DF4_D0F3_3173;

   typedef enum logic {
      PH_RUN  = 1'b0,
      PH_SEED = 1'b1
   } pcg_phase_e;

endpackage

// File: rtl/pcg_lcg_step.sv
module pcg_lcg_step #(
   parameter int                 STATE_W = 64,
   parameter logic [STATE_W-1:0] MULT    = pcg_pkg::PCG_MULT_64
) (
   input  logic [STATE_W-1:0] state_i,
   input  logic [STATE_W-1:0] inc_i,
   output logic [STATE_W-1:0] next_o
);

   if (MULT[0] != 1'b1) begin : g_bad_mult
      $error("pcg_lcg_step: multiplier must be odd");
   end

   // modular product and sum: the result width truncates to 2^STATE_W
   assign next_o = state_i * MULT + inc_i;

endmodule

// File: rtl/pcg_xsh_rr.sv
module pcg_xsh_rr #(
   parameter int STATE_W = 64,
   parameter int OUT_W   = 32,
   parameter bit BARREL  = 1'b1
) (
   input  logic [STATE_W-1:0] state_i,
   output logic [OUT_W-1:0]   word_o
);

   localparam int ROT_W    = $clog2(OUT_W);
   localparam int LOW_DROP = STATE_W - ROT_W - OUT_W;
   localparam int XSH      = (STATE_W - LOW_DROP) / 2;

   if (OUT_W != (1 << ROT_W)) begin : g_bad_out
      $error("pcg_xsh_rr: OUT_W must be a power of two");
   end
   if (LOW_DROP < 0) begin : g_bad_state
      $error("pcg_xsh_rr: state too narrow for the output window");
   end

   logic [OUT_W-1:0] pre;
   logic [ROT_W-1:0] amt;

   assign amt = state_i[STATE_W-1 -: ROT_W];
   assign pre = OUT_W'((state_i ^ (state_i >> XSH)) >> LOW_DROP);

   if (BARREL) begin : g_barrel
      logic [OUT_W-1:0] stg [ROT_W+1];
      assign stg[0] = pre;
      for (genvar k = 0; k < ROT_W; k++) begin : g_stage
         localparam int SH = 1 << k;
         assign stg[k+1] = amt[k] ? {stg[k][SH-1:0], stg[k][OUT_W-1:SH]}
                                  : stg[k];
      end
      assign word_o = stg[ROT_W];
   end else begin : g_shift_or
      assign word_o = (pre >> amt) | (pre << (OUT_W - int'(amt)));
   end

   // rotating the result left by the same amount must give back the window
   always_comb begin
      if (!$isunknown(state_i)) begin
         p_rotate_inverse_r4: assert (((word_o << amt) |
                                      (word_o >> (OUT_W - int'(amt)))) == pre);
      end
   end

   // zero rotate amount is a pass-through
   always_comb begin
      if (!$isunknown(state_i) && amt == '0) begin
         p_zero_rotate_r10: assert (word_o == pre);
      end
   end

endmodule

// File: rtl/pcg_rng.sv
module pcg_rng #(
   parameter int                 STATE_W    = 64,
   parameter int                 OUT_W      = 32,
   parameter logic [STATE_W-1:0] MULT       = pcg_pkg::PCG_MULT_64,
   parameter logic [STATE_W-1:0] DEF_INC    = pcg_pkg::PCG_INC_64,
   parameter logic [STATE_W-1:0] INIT_STATE = pcg_pkg::PCG_INIT_64,
   parameter bit                 ROT_BARREL = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               load_i,
   input  logic [STATE_W-1:0] seed_i,
   input  logic [STATE_W-1:0] stream_i,
   input  logic               next_i,
   output logic [OUT_W-1:0]   rand_o,
   output logic               valid_o
);

   import pcg_pkg::*;

   if (STATE_W != 2 * OUT_W) begin : g_bad_ratio
      $error("pcg_rng: state must be twice the output width");
   end
   if (DEF_INC[0] != 1'b1) begin : g_bad_inc
      $error("pcg_rng: default increment must be odd");
   end

   logic [STATE_W-1:0] state_q;
   logic [STATE_W-1:0] inc;
   logic [STATE_W-1:0] stepped;
   logic [OUT_W-1:0]   word;
   pcg_phase_e         phase_q;

   // stream selection keeps the increment odd whatever stream_i holds
   assign inc = (DEF_INC ^ stream_i) | STATE_W'(1);

   pcg_lcg_step #(
      .STATE_W (STATE_W),
      .MULT    (MULT)
   ) u_step (
      .state_i (state_q),
      .inc_i   (inc),
      .next_o  (stepped)
   );

   pcg_xsh_rr #(
      .STATE_W (STATE_W),
      .OUT_W   (OUT_W),
      .BARREL  (ROT_BARREL)
   ) u_perm (
      .state_i (state_q),
      .word_o  (word)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= INIT_STATE;
         phase_q <= PH_RUN;
         rand_o  <= '0;
         valid_o <= 1'b0;
      end else if (load_i) begin
         state_q <= seed_i + inc;
         phase_q <= PH_SEED;
         valid_o <= 1'b0;
      end else if (phase_q == PH_SEED) begin
         state_q <= stepped;
         phase_q <= PH_RUN;
         valid_o <= 1'b0;
      end else if (next_i) begin
         state_q <= stepped;
         rand_o  <= word;
         valid_o <= 1'b1;
      end else begin
         valid_o <= 1'b0;
      end
   end

   p_valid_needs_next_r9: assert property (@(posedge clk) disable iff (rst)
      valid_o |-> ($past(next_i) && !$past(load_i)));

   p_load_wins_r7: assert property (@(posedge clk) disable iff (rst)
      load_i |=> !valid_o);

   p_setup_silent_r6: assert property (@(posedge clk) disable iff (rst)
      (phase_q == PH_SEED) |=> (!valid_o && phase_q == PH_RUN));

   p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
      (!load_i && !next_i && phase_q == PH_RUN) |=> $stable(state_q));

   p_setup_ignores_next_r8: assert property (@(posedge clk) disable iff (rst)
      (phase_q == PH_SEED && !load_i && next_i) |=> !valid_o);

endmodule

// File: tb/pcg_rng_test.sv
module pcg_rng_test;

   localparam int CLK_PERIOD = 10;
   localparam logic [63:0] M_MUL  = 64'd6364136223846793005;
   localparam logic [63:0] M_INC  = 64'd1442695040888963407;
   localparam logic [63:0] M_INIT = 64'h4d595df4d0f33173;
   localparam int NVEC = 6;
   // {seed, stream, gap cycles between requests}
   localparam logic [135:0] VEC [NVEC] = '{
      {64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 8'd0},
      {64'h0000_0000_0000_002A, 64'h0000_0000_0000_0000, 8'd1},
      {64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0036, 8'd3},
      {64'h1234_5678_9ABC_DEF0, 64'hDEAD_BEEF_0000_0001, 8'd0},
      {64'h8000_0000_0000_0000, 64'h0000_0000_0000_0000, 8'd5},
      {64'hCAFE_F00D_D15E_A5E5, 64'h0F0F_0F0F_0F0F_0F0E, 8'd2}
   };

   logic        clk = 1'b0;
   logic        rst;
   logic        load_i;
   logic [63:0] seed_i;
   logic [63:0] stream_i;
   logic        next_i;
   logic [31:0] rand_o;
   logic        valid_o;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;
   logic [63:0] mst;

   pcg_rng uut (
      .clk      (clk),
      .rst      (rst),
      .load_i   (load_i),
      .seed_i   (seed_i),
      .stream_i (stream_i),
      .next_i   (next_i),
      .rand_o   (rand_o),
      .valid_o  (valid_o)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   function automatic logic [63:0] m_inc(input logic [63:0] s);
      return (M_INC ^ s) | 64'd1;
   endfunction

   function automatic logic [63:0] m_step(input logic [63:0] st, input logic [63:0] s);
      return st * M_MUL + m_inc(s);
   endfunction

   function automatic logic [31:0] m_window(input logic [63:0] st);
      logic [63:0] x;
      x = st ^ (st >> 18);
      return x[58:27];
   endfunction

   function automatic logic [31:0] m_perm(input logic [63:0] st);
      logic [31:0] w;
      w = m_window(st);
      for (int i = 0; i < int'(st[63:59]); i++) w = {w[0], w[31:1]};
      return w;
   endfunction

   // state that steps to target t under stream s
   function automatic logic [63:0] m_prev(input logic [63:0] t, input logic [63:0] s);
      logic [63:0] inv;
      inv = M_MUL;
      for (int i = 0; i < 6; i++) inv = inv * (64'd2 - M_MUL * inv);
      return (t - m_inc(s)) * inv;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic req_word(input string tag);
      next_i = 1'b1;
      tick();
      next_i = 1'b0;
      chk(valid_o === 1'b1, {tag, " valid"}, 64'(valid_o), 64'd1);
      chk(rand_o === m_perm(mst), {tag, " word"}, 64'(rand_o), 64'(m_perm(mst)));
      mst = m_step(mst, stream_i);
   endtask

   task automatic load_seed(input logic [63:0] sd, input logic [63:0] sm);
      seed_i   = sd;
      stream_i = sm;
      load_i   = 1'b1;
      tick();
      load_i = 1'b0;
      chk(valid_o === 1'b0, "R6 load cycle valid", 64'(valid_o), 64'd0);
      tick();
      chk(valid_o === 1'b0, "R6 setup cycle valid", 64'(valid_o), 64'd0);
      mst = m_step(sd + m_inc(sm), sm);
   endtask

   initial begin
      rst = 1'b1; load_i = 1'b0; next_i = 1'b0;
      seed_i = '0; stream_i = '0;
      repeat (3) tick();
      chk(valid_o === 1'b0, "R1 valid in reset", 64'(valid_o), 64'd0);
      rst = 1'b0;
      tick();
      chk(valid_o === 1'b0, "R1 valid after reset", 64'(valid_o), 64'd0);

      // R1 R5: first word comes from the reset state itself
      mst = M_INIT;
      req_word("R1 R5 first word");
      chk(valid_o === 1'b1, "R9 pulse present", 64'(valid_o), 64'd1);
      tick();
      chk(valid_o === 1'b0, "R9 single-cycle valid", 64'(valid_o), 64'd0);
      req_word("R2 R5 second word");
      req_word("R2 third word");

      // table of seeds and streams (R2 R3 R6 R9)
      for (int v = 0; v < NVEC; v++) begin
         load_seed(VEC[v][135:72], VEC[v][71:8]);
         for (int k = 0; k < 3; k++) begin
            req_word("R3 R9 table word");
            for (int g = 0; g < int'(VEC[v][7:0]); g++) begin
               tick();
               chk(valid_o === 1'b0, "R9 idle valid", 64'(valid_o), 64'd0);
            end
         end
      end

      // R7: load and next together
      seed_i = 64'h0000_1111_2222_3333; stream_i = '0;
      load_i = 1'b1; next_i = 1'b1;
      tick();
      load_i = 1'b0; next_i = 1'b0;
      chk(valid_o === 1'b0, "R7 no word on joint strobe", 64'(valid_o), 64'd0);
      tick();
      mst = m_step(seed_i + m_inc(stream_i), stream_i);
      req_word("R7 sequence after joint strobe");

      // R8: next during the setup cycle is dropped
      seed_i = 64'h0000_0000_0000_0777; stream_i = 64'h0000_0000_0000_0010;
      load_i = 1'b1;
      tick();
      load_i = 1'b0; next_i = 1'b1;
      tick();
      next_i = 1'b0;
      chk(valid_o === 1'b0, "R8 setup-cycle next ignored", 64'(valid_o), 64'd0);
      mst = m_step(seed_i + m_inc(stream_i), stream_i);
      req_word("R8 single advance");

      // R10: state placed with rotate field zero
      begin
         logic [63:0] tgt;
         tgt = 64'h0123_4567_89AB_CDEF;
         stream_i = '0;
         load_seed(m_prev(tgt, 64'd0) - m_inc(64'd0), 64'd0);
         next_i = 1'b1;
         tick();
         next_i = 1'b0;
         chk(rand_o === m_window(tgt), "R10 zero rotate passes window",
             64'(rand_o), 64'(m_window(tgt)));
         // R4: rotate field one
         tgt = 64'h0FED_CBA9_8765_4321;
         load_seed(m_prev(tgt, 64'd0) - m_inc(64'd0), 64'd0);
         next_i = 1'b1;
         tick();
         next_i = 1'b0;
         chk(rand_o === {m_window(tgt)[0], m_window(tgt)[31:1]},
             "R4 rotate by one", 64'(rand_o),
             64'({m_window(tgt)[0], m_window(tgt)[31:1]}));
      end

      // R1: reset mid-run restores the starting state
      rst = 1'b1;
      tick();
      chk(valid_o === 1'b0, "R1 valid on re-reset", 64'(valid_o), 64'd0);
      rst = 1'b0; stream_i = '0;
      mst = M_INIT;
      req_word("R1 word after re-reset");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule